// File: doc/BRIEF.md
# Non-Volatile Memory Program/Erase Timebase Prescaler

This block produces the slow timebase that a non-volatile memory command engine uses to time its program and erase pulses. The timebase comes from the oscillator, which is modelled as a one-cycle enable (`osc_en`) in the system clock domain. It does not come from the bus clock, so pulse timing stays the same when the bus frequency is scaled. Software writes the configuration once after reset. The write carries a select bit for an optional fixed divide-by-8 pre-stage and a 6-bit divisor N. From then on the block emits a one-cycle `tb_tick` once every (1+N) pre-stage outputs.

Memory commands depend on the configuration having been written. `div_loaded` reports that the configuration write has happened. A memory request made before that point raises a one-cycle `acc_err` pulse. `rate_ok` reports whether the configured rate can support program and erase: the oscillator rate divided by the total ratio must reach 150 kHz. The block is controlled by a two-state machine. In `ST_UNINIT` the counters are held idle, and the first `cfg_wr` causes the transition `UNINIT->LOADED`. `ST_LOADED` only ever returns to itself, so every later write is dropped.

Top module: `nvm_timebase`

## Requirements
- R1: During and straight after reset, `div_loaded`, `tb_tick`, `acc_err` and `rate_ok` are all 0.
- R2: A `cfg_wr` sampled in `ST_UNINIT` sets `div_loaded` in the following cycle. The flag then stays at 1 until reset.
- R3: While `div_loaded` is 1, `cfg_wr` has no effect. The tick spacing and `rate_ok` keep the values from the first write.
- R4: When `cfg_prediv`=0, one tick is produced for every (1+N) `osc_en` pulses counted after the load edge. With N=0 that is one tick for every pulse.
- R5: When `cfg_prediv`=1, one tick is produced for every 8*(1+N) `osc_en` pulses counted after the load edge.
- R6: `tb_tick` is registered. It is high for exactly the one cycle after the clock edge that sampled the completing `osc_en` pulse.
- R7: A `mem_req` sampled while unloaded gives `acc_err`=1 in the next cycle only. A `mem_req` sampled while loaded never raises `acc_err`.
- R8: `rate_ok` becomes 1 at load when OSC_KHZ >= 150*(cfg_prediv ? 8 : 1)*(1+N), and 0 otherwise. With the default OSC_KHZ of 8000, N=52 direct passes, N=53 direct fails, N=5 pre-divided passes and N=6 pre-divided fails. `rate_ok` is 0 while unloaded.
- R9: No tick is produced before the load, whatever the state of `osc_en`. `osc_en` pulses sampled at or before the load edge are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_prediv | input | 1 | 1 selects the divide-by-8 pre-stage |
| cfg_div | input | 6 | Divisor N; the ratio is 1+N |
| mem_req | input | 1 | Access to the memory address space |
| div_loaded | output | 1 | The configuration has been written since reset |
| tb_tick | output | 1 | One-cycle timebase pulse |
| acc_err | output | 1 | Pulse flagging an access made before the load |
| rate_ok | output | 1 | The configured timebase reaches the minimum rate |

## Verification
Each type of internal fault shows up at the ports in its own way and at its own time:
- A wrong count in the divider or the pre-stage shifts the cycle of a tick. The fault is visible at the first tick after the load, which comes at most 8*64 oscillator pulses after it.
- A state machine that leaves `ST_UNINIT` too early, or that re-enters it, shows as an early tick, a dropped `div_loaded` or a missing `acc_err` one cycle after a probe.
- A configuration register that accepts a second write changes the tick spacing within one count period of that write.
- A wrong rate comparison appears on `rate_ok` in the cycle after the load.

// File: rtl/nvt_pkg.sv
package nvt_pkg;
    typedef enum logic [0:0] {
        ST_UNINIT = 1'b0,
        ST_LOADED = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/nvt_cfg_fsm.sv
module nvt_cfg_fsm
    import nvt_pkg::*;
#(
    parameter int unsigned DIV_W     = 6,
    parameter int unsigned PRE_RATIO = 8,
    parameter int unsigned OSC_KHZ   = 8000,
    parameter int unsigned MIN_KHZ   = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_prediv,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             mem_req,
    output logic             run,
    output logic             load_pulse,
    output logic             prediv_q,
    output logic [DIV_W-1:0] div_q,
    output logic             acc_err,
    output logic             rate_ok
);
    cfg_state_e state_q, state_d;
    logic       err_d;
    logic       ok_d;
    int unsigned need_khz;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNINIT;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        run        = 1'b0;
        load_pulse = 1'b0;
        err_d      = 1'b0;
        unique case (state_q)
            ST_UNINIT: begin
                err_d      = mem_req;
                load_pulse = cfg_wr;
                if (cfg_wr) state_d = ST_LOADED;
            end
            ST_LOADED: begin
                run = 1'b1;
            end
        endcase
    end

    always_comb begin
        need_khz = MIN_KHZ * (cfg_prediv ? PRE_RATIO : 32'd1) * (32'(cfg_div) + 32'd1);
        ok_d     = (OSC_KHZ >= need_khz);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prediv_q <= 1'b0;
            div_q    <= '0;
            rate_ok  <= 1'b0;
            acc_err  <= 1'b0;
        end else begin
            acc_err <= err_d;
            if (load_pulse) begin
                prediv_q <= cfg_prediv;
                div_q    <= cfg_div;
                rate_ok  <= ok_d;
            end
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> ($stable(div_q) && $stable(prediv_q) && $stable(rate_ok))); // R3
endmodule

// File: rtl/nvt_prediv.sv
module nvt_prediv #(
    parameter int unsigned PRE_RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel,
    input  logic osc_en,
    output logic stage_en
);
    localparam int unsigned PRE_W = (PRE_RATIO > 2) ? $clog2(PRE_RATIO) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);

    logic [PRE_W-1:0] cnt_q;
    logic             last;

    assign last     = (cnt_q == PRE_LAST);
    assign stage_en = run && osc_en && (!sel || last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run)           cnt_q <= '0;
        else if (sel && osc_en)  cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/nvt_divcnt.sv
module nvt_divcnt #(
    parameter int unsigned DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] reload_val,
    input  logic             stage_en,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = stage_en && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= wrap && !load;
            if (load)          cnt_q <= load_val;
            else if (wrap)     cnt_q <= reload_val;
            else if (stage_en) cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_TICK_AFTER_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(stage_en)); // R6
endmodule

// File: rtl/nvm_timebase.sv
module nvm_timebase #(
    parameter int unsigned DIV_W     = 6,
    parameter int unsigned PRE_RATIO = 8,
    parameter int unsigned OSC_KHZ   = 8000,
    parameter int unsigned MIN_KHZ   = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             cfg_wr,
    input  logic             cfg_prediv,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             mem_req,
    output logic             div_loaded,
    output logic             tb_tick,
    output logic             acc_err,
    output logic             rate_ok
);
    logic             run;
    logic             load_pulse;
    logic             prediv_q;
    logic [DIV_W-1:0] div_q;
    logic             stage_en;

    nvt_cfg_fsm #(
        .DIV_W(DIV_W), .PRE_RATIO(PRE_RATIO), .OSC_KHZ(OSC_KHZ), .MIN_KHZ(MIN_KHZ)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_prediv(cfg_prediv),
        .cfg_div(cfg_div), .mem_req(mem_req), .run(run), .load_pulse(load_pulse),
        .prediv_q(prediv_q), .div_q(div_q), .acc_err(acc_err), .rate_ok(rate_ok)
    );

    nvt_prediv #(.PRE_RATIO(PRE_RATIO)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(prediv_q),
        .osc_en(osc_en), .stage_en(stage_en)
    );

    nvt_divcnt #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(load_pulse), .load_val(cfg_div),
        .reload_val(div_q), .stage_en(stage_en), .tick(tb_tick)
    );

    assign div_loaded = run;

    AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        div_loaded |=> div_loaded); // R2
    AST_NO_TICK_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
        !div_loaded |-> !tb_tick); // R9
    AST_ACCERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(mem_req && !div_loaded)); // R7
    AST_RATE_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
        !div_loaded |-> !rate_ok); // R8
endmodule

// File: tb/nvm_timebase_tb_top.sv
module nvm_timebase_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_prediv = 1'b0;
    logic [5:0] cfg_div = '0;
    logic       mem_req = 1'b0;
    logic       div_loaded, tb_tick, acc_err, rate_ok;

    int ecount = 0;
    int osc_per = 1;
    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    int exp_q[$];
    string cur_req = "R4";

    always #5 clk = ~clk;

    nvm_timebase dut_i (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cfg_wr(cfg_wr),
        .cfg_prediv(cfg_prediv), .cfg_div(cfg_div), .mem_req(mem_req),
        .div_loaded(div_loaded), .tb_tick(tb_tick), .acc_err(acc_err), .rate_ok(rate_ok)
    );

    always @(posedge clk) ecount <= ecount + 1;

    // oscillator enable: edge e sees osc_en when e % osc_per == 0
    always @(negedge clk) osc_en = (((ecount + 1) % osc_per) == 0);

    task automatic check(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // monitor: compare each observed tick with the scoreboard head
    always @(negedge clk) begin
        if (mon_on && tb_tick) begin
            if (exp_q.size() == 0) check(cur_req, "unexpected tick at edge", ecount, -1);
            else check(cur_req, "tick edge", ecount, exp_q.pop_front());
        end
    end

    task automatic run_phase(input bit pre, input int div, input int per, input int win,
                             input bit exp_rate, input string req);
        int l_edge;
        int pulses;
        int m;
        cur_req = req;
        osc_per = per;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "loaded in reset", int'(div_loaded), 0);
        check("R1", "tick in reset", int'(tb_tick), 0);
        check("R1", "acc_err in reset", int'(acc_err), 0);
        check("R1", "rate_ok in reset", int'(rate_ok), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mem_req = 1'b1;
        @(negedge clk);
        mem_req = 1'b0;
        check("R7", "acc_err after early access", int'(acc_err), 1);
        check("R9", "tick before load", int'(tb_tick), 0);
        @(negedge clk);
        check("R7", "acc_err one cycle", int'(acc_err), 0);
        // load
        cfg_wr = 1'b1; cfg_prediv = pre; cfg_div = 6'(div);
        l_edge = ecount + 1;
        m = (pre ? 8 : 1) * (1 + div);
        pulses = 0;
        for (int e = l_edge + 1; e <= l_edge + win; e++) begin
            if (e % per == 0) begin
                pulses++;
                if (pulses % m == 0) exp_q.push_back(e);
            end
        end
        mon_on = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R2", "loaded after write", int'(div_loaded), 1);
        check("R8", "rate_ok", int'(rate_ok), int'(exp_rate));
        mem_req = 1'b1;
        @(negedge clk);
        mem_req = 1'b0;
        @(negedge clk);
        check("R7", "acc_err when loaded", int'(acc_err), 0);
        while (ecount < l_edge + win / 2) @(negedge clk);
        // second write must be ignored
        cfg_wr = 1'b1; cfg_prediv = ~pre; cfg_div = 6'((div + 17) % 64);
        @(negedge clk);
        cfg_wr = 1'b0;
        while (ecount < l_edge + win) @(negedge clk);
        #1;
        mon_on = 1'b0;
        check(req, "missing ticks", exp_q.size(), 0);
        exp_q.delete();
        check("R3", "rate_ok after rewrite", int'(rate_ok), int'(exp_rate));
        check("R2", "loaded still set", int'(div_loaded), 1);
    endtask

    initial begin
        run_phase(1'b0, 0,  1, 20,  1'b1, "R4");
        run_phase(1'b0, 5,  3, 60,  1'b1, "R3");
        run_phase(1'b1, 2,  2, 120, 1'b1, "R5");
        run_phase(1'b1, 6,  1, 130, 1'b0, "R5");
        run_phase(1'b1, 5,  1, 100, 1'b1, "R8");
        run_phase(1'b0, 53, 1, 60,  1'b0, "R8");
        run_phase(1'b0, 52, 1, 60,  1'b1, "R6");
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule